// File: doc/BRIEF.md
# Address Register Update Unit

This unit serves register-indirect memory accesses. On each request it takes the current value of an address register, an offset value and a 3-bit mode code. From these it forms the effective address for the access and the value the address register should hold afterwards. A write-enable tells the register file whether that new value must be stored.

Seven modes are served by one shared adder/subtractor:
- leave the register alone;
- step it by one or by the offset, up or down, after the access;
- address through register plus offset without changing the register;
- step the register down by one before the access.

All arithmetic is plain linear modular arithmetic at the data width. No flags are produced. Results are registered and appear one clock after the request.

Top module: `addr_update_unit`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `res_valid`, `reg_we`, `eff_addr` and `reg_next` are all zero.
- R2: `res_valid` is high exactly in the cycle after a cycle in which `req` was high. A cycle without a request yields `res_valid` and `reg_we` low in the following cycle.
- R3: Mode code 0 (hold): `eff_addr` is the old register value, `reg_next` equals the old register value and `reg_we` is low.
- R4: Mode code 1 (step up by one, after): `eff_addr` is the old register value, `reg_next` is old+1 and `reg_we` is high.
- R5: Mode code 2 (step down by one, after): `eff_addr` is the old register value, `reg_next` is old-1 and `reg_we` is high.
- R6: Mode code 3 (add offset, after): `eff_addr` is the old register value, `reg_next` is old+offset and `reg_we` is high.
- R7: Mode code 4 (subtract offset, after): `eff_addr` is the old register value, `reg_next` is old-offset and `reg_we` is high.
- R8: Mode code 5 (indexed): `eff_addr` is old+offset, `reg_next` equals the old register value and `reg_we` is low.
- R9: Mode code 6 (step down by one, before): both `eff_addr` and `reg_next` are old-1 and `reg_we` is high.
- R10: Mode code 7 is unused and behaves exactly as mode code 0.
- R11: All sums and differences wrap modulo 2^W: all-ones plus one gives zero, and zero minus one gives all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one access per cycle |
| mode | input | 3 | Addressing mode code |
| reg_val | input | W | Current address register value |
| ofs_val | input | W | Offset register value |
| res_valid | output | 1 | Results below are valid this cycle |
| eff_addr | output | W | Effective address of the access |
| reg_next | output | W | Value the address register should take |
| reg_we | output | 1 | Store `reg_next` into the address register |

## Verification
Every result of a request is due exactly one rising edge after the edge that captured it. This covers `res_valid`, `eff_addr`, `reg_next` and `reg_we`, and a cycle without a request likewise shows its low valid and low write-enable one edge later. The driver puts one expected item in a queue per driven cycle, idle cycles included, in the half period before the capturing edge. The monitor samples 2 ns after each rising edge and pops one item per cycle, so any off-by-one in latency shows as a mismatch.

// File: rtl/auu_pkg.sv
package auu_pkg;

  typedef enum logic [2:0] {
    MD_HOLD     = 3'd0,
    MD_POST_INC = 3'd1,
    MD_POST_DEC = 3'd2,
    MD_POST_ADD = 3'd3,
    MD_POST_SUB = 3'd4,
    MD_INDEX    = 3'd5,
    MD_PRE_DEC  = 3'd6,
    MD_SPARE    = 3'd7
  } auu_mode_e;

  // Control word derived from the mode code
  typedef struct packed {
    logic use_ofs;   // step by offset instead of one
    logic subtract;  // subtract the step
    logic pre;       // effective address is the stepped value
    logic write;     // register is updated
  } auu_ctrl_t;

endpackage

// File: rtl/auu_mode_decode.sv
module auu_mode_decode
  import auu_pkg::*;
(
  input  logic [2:0] mode,
  output auu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (mode)
      MD_POST_INC: ctrl = '{use_ofs: 1'b0, subtract: 1'b0, pre: 1'b0, write: 1'b1};
      MD_POST_DEC: ctrl = '{use_ofs: 1'b0, subtract: 1'b1, pre: 1'b0, write: 1'b1};
      MD_POST_ADD: ctrl = '{use_ofs: 1'b1, subtract: 1'b0, pre: 1'b0, write: 1'b1};
      MD_POST_SUB: ctrl = '{use_ofs: 1'b1, subtract: 1'b1, pre: 1'b0, write: 1'b1};
      MD_INDEX:    ctrl = '{use_ofs: 1'b1, subtract: 1'b0, pre: 1'b1, write: 1'b0};
      MD_PRE_DEC:  ctrl = '{use_ofs: 1'b0, subtract: 1'b1, pre: 1'b1, write: 1'b1};
      default:     ctrl = '0;  // hold and the spare code
    endcase
  end

endmodule

// File: rtl/auu_stepper.sv
module auu_stepper
  import auu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] ofs,
  input  auu_ctrl_t    ctrl,
  output logic [W-1:0] stepped
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] step_value(input logic [W-1:0] b,
                                              input logic [W-1:0] s,
                                              input logic         sub);
    step_value = sub ? (b - s) : (b + s);
  endfunction

  logic [W-1:0] step_amt;

  assign step_amt = ctrl.use_ofs ? ofs : ONE;
  assign stepped  = step_value(base, step_amt, ctrl.subtract);

endmodule

// File: rtl/addr_update_unit.sv
module addr_update_unit
  import auu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [2:0]   mode,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] ofs_val,
  output logic         res_valid,
  output logic [W-1:0] eff_addr,
  output logic [W-1:0] reg_next,
  output logic         reg_we
);

  auu_ctrl_t    ctrl;
  logic [W-1:0] stepped;
  logic [W-1:0] addr_d;
  logic [W-1:0] next_d;
  logic         wr_event;

  auu_mode_decode u_dec (
    .mode (mode),
    .ctrl (ctrl)
  );

  auu_stepper #(.W(W)) u_step (
    .base    (reg_val),
    .ofs     (ofs_val),
    .ctrl    (ctrl),
    .stepped (stepped)
  );

  assign addr_d   = ctrl.pre   ? stepped : reg_val;
  assign next_d   = ctrl.write ? stepped : reg_val;
  assign wr_event = req & ctrl.write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      reg_we    <= 1'b0;
      eff_addr  <= '0;
      reg_next  <= '0;
    end else begin
      res_valid <= req;
      reg_we    <= wr_event;
      if (req) begin
        eff_addr <= addr_d;
        reg_next <= next_d;
      end
    end
  end

endmodule

// File: rtl/auu_checker.sv
module auu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic [2:0]   mode,
  input logic [W-1:0] reg_val,
  input logic [W-1:0] ofs_val,
  input logic         res_valid,
  input logic [W-1:0] eff_addr,
  input logic [W-1:0] reg_next,
  input logic         reg_we
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(!rst_n) |-> (!res_valid && !reg_we));

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);

  // R2
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> res_valid);

  // R3
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd0) |=> (!reg_we && eff_addr == $past(reg_val) && reg_next == $past(reg_val)));

  // R4
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd1) |=> (reg_we && eff_addr == $past(reg_val) && reg_next == $past(reg_val) + ONE));

  // R5
  post_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd2) |=> (reg_we && eff_addr == $past(reg_val) && reg_next == $past(reg_val) - ONE));

  // R6
  post_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd3) |=> (reg_we && eff_addr == $past(reg_val) && reg_next == $past(reg_val) + $past(ofs_val)));

  // R7
  post_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd4) |=> (reg_we && eff_addr == $past(reg_val) && reg_next == $past(reg_val) - $past(ofs_val)));

  // R8
  indexed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd5) |=> (!reg_we && eff_addr == $past(reg_val) + $past(ofs_val) && reg_next == $past(reg_val)));

  // R9
  pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd6) |=> (reg_we && eff_addr == $past(reg_val) - ONE && reg_next == eff_addr));

  // R10
  spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd7) |=> (!reg_we && eff_addr == $past(reg_val) && reg_next == $past(reg_val)));

endmodule

bind addr_update_unit auu_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .mode      (mode),
  .reg_val   (reg_val),
  .ofs_val   (ofs_val),
  .res_valid (res_valid),
  .eff_addr  (eff_addr),
  .reg_next  (reg_next),
  .reg_we    (reg_we)
);

// File: tb/addr_update_unit_test.sv
`timescale 1ns/1ps
module addr_update_unit_test;

  localparam int W = 32;

  typedef struct {
    logic         valid;
    logic [W-1:0] addr;
    logic [W-1:0] nxt;
    logic         we;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic [W-1:0] reg_val = '0;
  logic [W-1:0] ofs_val = '0;
  logic         res_valid;
  logic [W-1:0] eff_addr;
  logic [W-1:0] reg_next;
  logic         reg_we;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  addr_update_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .reg_val(reg_val), .ofs_val(ofs_val), .res_valid(res_valid),
    .eff_addr(eff_addr), .reg_next(reg_next), .reg_we(reg_we)
  );

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected results written from the requirement table
  function automatic exp_t model(input logic [2:0] m, input logic [W-1:0] r,
                                 input logic [W-1:0] o, input string tag);
    exp_t e;
    e.valid = 1'b1;
    e.tag   = tag;
    e.addr  = r;
    e.nxt   = r;
    e.we    = 1'b0;
    case (m)
      3'd1: begin e.nxt = r + 1;  e.we = 1'b1; end
      3'd2: begin e.nxt = r - 1;  e.we = 1'b1; end
      3'd3: begin e.nxt = r + o;  e.we = 1'b1; end
      3'd4: begin e.nxt = r - o;  e.we = 1'b1; end
      3'd5: begin e.addr = r + o; end
      3'd6: begin e.addr = r - 1; e.nxt = r - 1; e.we = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] m, input logic [W-1:0] r,
                       input logic [W-1:0] o, input string tag);
    @(negedge clk);
    req = 1'b1; mode = m; reg_val = r; ofs_val = o;
    sb.push_back(model(m, r, o, tag));
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    req = 1'b0; mode = 3'd3; reg_val = 32'hDEAD_0000; ofs_val = 32'h1;
    e.valid = 1'b0; e.we = 1'b0; e.addr = '0; e.nxt = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: one expected item per cycle, sampled just after the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "res_valid", W'(res_valid), W'(e.valid));
      check(e.tag, "reg_we", W'(reg_we), W'(e.we));
      if (e.valid) begin
        check(e.tag, "eff_addr", eff_addr, e.addr);
        check(e.tag, "reg_next", reg_next, e.nxt);
      end
    end
  end

  initial begin
    #((8 * 100000));
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    req = 1'b1; mode = 3'd1; reg_val = 32'h55; ofs_val = 32'h3;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs stay zero while reset is held even with a request present
    check("R1", "res_valid", W'(res_valid), '0);
    check("R1", "reg_we", W'(reg_we), '0);
    check("R1", "eff_addr", eff_addr, '0);
    check("R1", "reg_next", reg_next, '0);
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b1;

    drive(3'd0, 32'h0000_1000, 32'h0000_0010, "R3");
    drive(3'd1, 32'h0000_2000, 32'h0000_0010, "R4");
    drive(3'd2, 32'h0000_3000, 32'h0000_0010, "R5");
    drive(3'd3, 32'h0000_4000, 32'h0000_0123, "R6");
    drive(3'd4, 32'h0000_5000, 32'h0000_0456, "R7");
    drive(3'd5, 32'h0000_6000, 32'h0000_0789, "R8");
    drive(3'd6, 32'h0000_7000, 32'h0000_0abc, "R9");
    drive(3'd7, 32'h0000_8000, 32'h0000_0def, "R10");
    idle("R2");
    idle("R2");
    drive(3'd4, 32'h0000_0010, 32'h0000_0010, "R7");
    // R11: wrap-around at both ends
    drive(3'd1, 32'hFFFF_FFFF, 32'h0, "R11");
    drive(3'd6, 32'h0000_0000, 32'h0, "R11");
    drive(3'd2, 32'h0000_0000, 32'h0, "R11");
    drive(3'd3, 32'hFFFF_FFF0, 32'h0000_0020, "R11");
    drive(3'd5, 32'h8000_0000, 32'h8000_0001, "R11");
    drive(3'd4, 32'h0000_0001, 32'h0000_0003, "R11");
    idle("R2");
    drive(3'd7, 32'hCAFE_F00D, 32'h1234_5678, "R10");
    drive(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    // Back-to-back sweep of every code with varying operands
    for (int i = 0; i < 24; i++) begin
      drive(3'(i % 8), 32'h1357_0000 + 32'(i * 977), 32'(i * 31 + 5), "R2");
    end
    idle("R2");
    @(negedge clk);
    req = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule